// File: doc/BRIEF.md
# Reference Noise Channel Selector

This block sits behind a bank of per-channel time-delay estimators in an adaptive noise canceller. Each time the estimators finish a sample, they present one signed delay value per reference channel together with a single strobe. The block keeps two running statistics for every channel: a smoothed mean of its delay estimate, and a smoothed mean absolute deviation of the estimate from that mean. A channel whose delay estimate wanders little is taken to be well correlated with the primary input. The most stable channel is chosen as the reference noise source.

After each accepted sample, the block updates all channel statistics in a single cycle. It then walks the channels one at a time to find the smallest deviation, and publishes the winning channel index together with that channel's delay for the same sample. The delay output drives the primary-path delay line, which lies outside this block, as does the computation of the estimates. Until enough samples have been seen for the statistics to mean anything, the block reports channel 0.

The controller is a four-state machine:
- ST_IDLE waits for the strobe. The transition "capture" latches all delays and moves to ST_UPDATE.
- ST_UPDATE applies the statistic update. The transition "begin scan" moves to ST_SCAN and clears the scan pointer.
- ST_SCAN compares one channel per cycle. The transition "scan done", taken on the last channel, moves to ST_PUBLISH.
- ST_PUBLISH registers the outputs. The transition "release" returns to ST_IDLE.

Top module: `rcs_ref_select`

## Requirements
- R1: After reset, sel_valid is 0, sel_index is 0 and sel_delay is 0, and they stay so until the first result is published.
- R2: A strobe seen in the idle state is captured. The matching result appears as a one-cycle sel_valid pulse NCH+2 clock edges after the capture edge.
- R3: Each channel keeps a mean M with AVG_SHIFT fraction bits, starting at 0. For a sample D it is updated as M += ((D<<AVG_SHIFT) − M) >>> AVG_SHIFT, where the arithmetic shift rounds toward minus infinity.
- R4: Each channel keeps a deviation average A, starting at 0. It is updated as A += (|(D<<AVG_SHIFT) − M_before| − A) >>> AVG_SHIFT, using the mean from before the same sample's update, and it never goes negative.
- R5: Once warm, sel_index is the channel with the smallest A after the current sample's update. When several channels share that smallest value, the lowest index wins.
- R6: For the first WARMUP−1 accepted samples, where WARMUP defaults to 64, the published index is 0. From sample number WARMUP onward, the rule of R5 applies.
- R7: sel_delay equals the delay of the published channel, taken from the sample that produced the result (channel c occupies est_delay[c*DW +: DW], two's complement).
- R8: A strobe that arrives while a sample is being processed, from the capture edge up to and including the publish edge, is ignored. It changes neither the statistics, nor the sample count, nor the published delay.
- R9: sel_index and sel_delay hold their value between published results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| est_valid | input | 1 | Strobe: a full set of channel delays is present |
| est_delay | input | NCH*DW | Signed delay per channel, channel c in bits c*DW +: DW |
| sel_valid | output | 1 | One-cycle pulse when a new selection is published |
| sel_index | output | max(1,clog2(NCH)) | Selected reference channel |
| sel_delay | output | DW | Delay of the selected channel for this sample |

## Verification
A corrupted mean or deviation register changes nothing at the ports during warm-up, because channel 0 is forced. Such a fault first shows as a wrong sel_index on the first warm result, and it can stay hidden until the ranking between channels actually flips. For that reason the stimulus gives channels very different noise levels, and runs a stretch in which one channel's history decides the winner. A wrong state sequence or a captured delay that is overwritten shows within one sample: the valid pulse lands on the wrong edge, or sel_delay differs from the value that was driven. Both are compared against the bench model on every clock.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_UPDATE  = 2'd1,
        ST_SCAN    = 2'd2,
        ST_PUBLISH = 2'd3
    } rcs_state_e;

endpackage

// File: rtl/rcs_chan_stats.sv
module rcs_chan_stats #(
    parameter int DW        = 16,
    parameter int AVG_SHIFT = 4,
    localparam int SW       = DW + AVG_SHIFT + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 update,
    input  logic signed [DW-1:0] sample,
    output logic signed [SW-1:0] mae_o
);

    logic signed [SW-1:0] mean_q;
    logic signed [SW-1:0] mae_q;
    logic signed [SW-1:0] scaled;
    logic signed [SW-1:0] err;
    logic signed [SW-1:0] dev;
    logic signed [SW-1:0] mean_step;
    logic signed [SW-1:0] mae_step;

    always_comb begin
        scaled    = $signed({{(SW-DW){sample[DW-1]}}, sample}) <<< AVG_SHIFT;
        err       = scaled - mean_q;
        dev       = err[SW-1] ? -err : err;
        mean_step = err >>> AVG_SHIFT;
        mae_step  = (dev - mae_q) >>> AVG_SHIFT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mean_q <= '0;
            mae_q  <= '0;
        end else if (update) begin
            mean_q <= mean_q + mean_step;
            mae_q  <= mae_q + mae_step;
        end
    end

    assign mae_o = mae_q;

    AST_STATS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> ($stable(mae_q) && $stable(mean_q))); // R3
    AST_MAE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        !mae_q[SW-1]); // R4

endmodule

// File: rtl/rcs_min_scan.sv
module rcs_min_scan #(
    parameter int NCH = 4,
    parameter int SW  = 22,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PW = $clog2(NCH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    run,
    input  logic [NCH-1:0][SW-1:0]  mae_bus,
    output logic                    last_o,
    output logic [IW-1:0]           best_idx_o
);

    logic [PW-1:0]        ptr_q;
    logic [IW-1:0]        cur_idx;
    logic signed [SW-1:0] cur_val;
    logic signed [SW-1:0] best_q;
    logic [IW-1:0]        best_idx_q;
    logic                 take;

    always_comb begin
        cur_idx = (ptr_q < PW'(NCH)) ? IW'(ptr_q) : '0;
        cur_val = $signed(mae_bus[cur_idx]);
        take    = (ptr_q == '0) || (cur_val < best_q);
        last_o  = run && (ptr_q == PW'(NCH - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            best_q     <= '0;
            best_idx_q <= '0;
        end else if (start) begin
            ptr_q <= '0;
        end else if (run) begin
            ptr_q <= ptr_q + 1'b1;
            if (take) begin
                best_q     <= cur_val;
                best_idx_q <= cur_idx;
            end
        end
    end

    assign best_idx_o = best_idx_q;

    AST_SCAN_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ptr_q != '0) |=> (best_q <= $past(best_q))); // R5
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PW'(NCH)); // R5

endmodule

// File: rtl/rcs_ref_select.sv
module rcs_ref_select
    import rcs_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int DW        = 16,
    parameter int AVG_SHIFT = 4,
    parameter int WARMUP    = 64,
    localparam int IW       = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SW       = DW + AVG_SHIFT + 2,
    localparam int CW       = $clog2(WARMUP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              est_valid,
    input  logic [NCH*DW-1:0] est_delay,
    output logic              sel_valid,
    output logic [IW-1:0]     sel_index,
    output logic [DW-1:0]     sel_delay
);

    rcs_state_e state_q, state_d;

    logic [NCH-1:0][DW-1:0] cap_q;
    logic [NCH-1:0][SW-1:0] mae_bus;
    logic [CW-1:0]          cnt_q;
    logic                   warm;
    logic                   capture;
    logic                   do_update;
    logic                   do_scan;
    logic                   scan_last;
    logic [IW-1:0]          best_idx;
    logic [IW-1:0]          pub_idx;

    assign capture   = (state_q == ST_IDLE) && est_valid;
    assign do_update = (state_q == ST_UPDATE);
    assign do_scan   = (state_q == ST_SCAN);
    assign warm      = (cnt_q == CW'(WARMUP));
    assign pub_idx   = warm ? best_idx : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (est_valid) state_d = ST_UPDATE;
            ST_UPDATE:  state_d = ST_SCAN;
            ST_SCAN:    if (scan_last) state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (capture) begin
            for (int c = 0; c < NCH; c++) cap_q[c] <= est_delay[c*DW +: DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (do_update && !warm)    cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        rcs_chan_stats #(
            .DW        (DW),
            .AVG_SHIFT (AVG_SHIFT)
        ) u_stats (
            .clk    (clk),
            .rst_n  (rst_n),
            .update (do_update),
            .sample (cap_q[g]),
            .mae_o  (mae_bus[g])
        );
    end

    rcs_min_scan #(
        .NCH (NCH),
        .SW  (SW)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (do_update),
        .run        (do_scan),
        .mae_bus    (mae_bus),
        .last_o     (scan_last),
        .best_idx_o (best_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_index <= '0;
            sel_delay <= '0;
        end else begin
            sel_valid <= (state_q == ST_PUBLISH);
            if (state_q == ST_PUBLISH) begin
                sel_index <= pub_idx;
                sel_delay <= cap_q[pub_idx];
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> !sel_valid); // R2
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(cap_q)); // R8
    AST_WARMUP_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && cnt_q < CW'(WARMUP)) |-> (sel_index == '0)); // R6
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, sel_index} < (IW+1)'(NCH)); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PUBLISH) |=> ($stable(sel_index) && $stable(sel_delay))); // R9

endmodule

// File: tb/sim_rcs_ref_select.sv
`timescale 1ns/1ps
module sim_rcs_ref_select;

    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int SH  = 4;
    localparam int WU  = 64;
    localparam int IW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              est_valid = 1'b0;
    logic [NCH*DW-1:0] est_delay = '0;
    logic              sel_valid;
    logic [IW-1:0]     sel_index;
    logic [DW-1:0]     sel_delay;

    int vectors = 0;
    int fails   = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    rcs_ref_select #(.NCH(NCH), .DW(DW), .AVG_SHIFT(SH), .WARMUP(WU)) u0 (
        .clk(clk), .rst_n(rst_n), .est_valid(est_valid), .est_delay(est_delay),
        .sel_valid(sel_valid), .sel_index(sel_index), .sel_delay(sel_delay)
    );

    // behavioural reference model
    int mm[NCH];
    int aa[NCH];
    int busy, nsamp, pend_i, pend_d, pend_n;
    int exp_v, exp_i, exp_d, exp_n;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin mm[c] = 0; aa[c] = 0; end
            busy = 0; nsamp = 0; exp_v = 0; exp_i = 0; exp_d = 0; exp_n = 0;
        end else begin
            exp_v = 0;
            if (busy > 0) begin
                busy--;
                if (busy == 0) begin
                    exp_v = 1; exp_i = pend_i; exp_d = pend_d; exp_n = pend_n;
                end
            end else if (est_valid) begin
                int dv[NCH];
                int bi;
                for (int c = 0; c < NCH; c++) begin
                    int e, dev;
                    dv[c] = int'($signed(est_delay[c*DW +: DW]));
                    e = dv[c] * (1 << SH) - mm[c];
                    dev = (e < 0) ? -e : e;
                    mm[c] = mm[c] + (e >>> SH);
                    aa[c] = aa[c] + ((dev - aa[c]) >>> SH);
                end
                if (nsamp < WU) nsamp++;
                bi = 0;
                for (int c = 1; c < NCH; c++) if (aa[c] < aa[bi]) bi = c;
                if (nsamp < WU) bi = 0;
                pend_i = bi; pend_d = dv[bi]; pend_n = nsamp;
                busy = NCH + 2;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (int'(sel_valid) != exp_v) begin
                fails++;
                $display("FAIL R2 [%s] sel_valid actual %0d expected %0d", phase, sel_valid, exp_v);
            end
            if (int'(sel_index) != exp_i) begin
                fails++;
                if (exp_n == 0)
                    $display("FAIL R1 [%s] sel_index actual %0d expected %0d", phase, sel_index, exp_i);
                else if (exp_n < WU)
                    $display("FAIL R6 [%s] sel_index actual %0d expected %0d", phase, sel_index, exp_i);
                else
                    $display("FAIL R5 (R3/R4 ranking, R9 hold) [%s] sel_index actual %0d expected %0d",
                             phase, sel_index, exp_i);
            end
            if (int'($signed(sel_delay)) != exp_d) begin
                fails++;
                $display("FAIL R7 (R9 hold) [%s] sel_delay actual %0d expected %0d",
                         phase, $signed(sel_delay), exp_d);
            end
        end
    end

    task automatic send(input int v0, input int v1, input int v2, input int v3, input int gap);
        @(negedge clk);
        est_valid = 1'b1;
        est_delay = {DW'(v3), DW'(v2), DW'(v1), DW'(v0)};
        @(negedge clk);
        est_valid = 1'b0;
        est_delay = {NCH*DW{1'b1}};
        repeat (NCH + 2 + gap) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        phase = "R1";
        do_reset();

        // R6 then R5: channels with distinct noise levels, through warm-up
        phase = "R6";
        for (int k = 0; k < 90; k++) begin
            if (k == WU) phase = "R5 noisy";
            send($urandom_range(4000) - 2000, $urandom_range(1000) - 500,
                 -300, $urandom_range(100) - 50, k % 3);
        end

        // R3/R4: extreme values stress the running mean and deviation
        phase = "R5 extremes";
        send(32767, -32768, 32767, -32768, 0);
        send(-32768, 32767, -32768, 32767, 1);
        for (int k = 0; k < 30; k++)
            send(12, $urandom_range(20000) - 10000, 12, 12 + (k % 2), 0);

        // R5 tie: identical history on every channel, lowest index must win
        phase = "R5 tie";
        do_reset();
        for (int k = 0; k < 75; k++) begin
            int v;
            v = $urandom_range(600) - 300;
            send(v, v, v, v, 0);
        end
        // channel 0 turns noisy, the ranking moves away from it
        phase = "R5 shift";
        for (int k = 0; k < 40; k++) begin
            int v;
            v = $urandom_range(600) - 300;
            send(v + $urandom_range(8000) - 4000, v, v, v + 1, 0);
        end

        // R8: strobe held high through busy cycles, values changing every cycle
        phase = "R8";
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            est_valid = 1'b1;
            est_delay = {DW'($urandom_range(2000)), DW'($urandom_range(200)),
                         DW'($urandom_range(9000)), DW'($urandom_range(50))};
        end
        @(negedge clk);
        est_valid = 1'b0;
        repeat (NCH + 4) @(negedge clk);

        // R9: long idle gaps between samples, outputs must hold
        phase = "R9";
        for (int k = 0; k < 12; k++)
            send($urandom_range(100), $urandom_range(3000), -7, $urandom_range(40), 5 + k * 3);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule